// File: doc/BRIEF.md
# Tick Counter Compare Timer Unit

This block holds a small set of free-running cycle counters, each paired with a compare register. Each counter advances by one on every cycle in which its tick enable is high. Software can load and read a counter and its compare value through a shared write port and a read port that selects one channel at a time. The top bit of every counter word is a sticky flag that is stored apart from the count. The top bit of every compare word is an interrupt-disable flag. A channel raises a one-cycle match pulse when its count reaches an enabled, nonzero compare value.

Each match pulse sets a bit in a two-bit software-interrupt register. Channel 0 drives bit 0, the timer bit. Every other channel drives bit 1, the system-timer bit, so the second and third channels share that bit. Software clears either bit with a clear strobe.

Some compare values lie at or below the count that the counter will hold after the write. Such a value is not lost: it fires on the channel's next tick. A compare value of zero, or a compare word with its disable flag set, cancels any pending match.

Top module: `tick_cmp_unit`

## Requirements
- R1: A counter write loads bits 62:0 of `wr_data` into the count and bit 63 into a stored flag. A counter read returns the count in bits 62:0 and the stored flag in bit 63.
- R2: A count advances by exactly one at each clock edge where its `tick_i` bit is high, and holds otherwise. A counter write in the same cycle takes priority over the advance.
- R3: A count at all ones in bits 62:0 advances to zero, and the stored flag in bit 63 keeps its value.
- R4: A compare write stores bits 62:0 as the limit and bit 63 as the disable flag. `rd_lim` returns the limit in bits 62:0 and the disable flag in bit 63.
- R5: Consider an enabled, nonzero limit that is above the count at the write. `match_o[i]` is high for one cycle, in the cycle after the edge at which the count advances to the limit.
- R6: A compare write produces at most one match. Further ticks past the limit produce no further pulse until the next compare write.
- R7: A compare write of zero in bits 62:0, or with bit 63 set, cancels any pending match. No pulse follows.
- R8: Consider an enabled, nonzero limit at or below the count held after the write edge. It matches at the channel's next tick.
- R9: One cycle after `match_o[0]`, bit 0 of `sint_q` is set. One cycle after `match_o[1]` or `match_o[2]`, bit 1 is set. A high `sint_clr` bit clears the matching bit, but a set in the same cycle wins.
- R10: Reset puts every channel in the following state: count zero, stored flag 1, limit zero, disable flag 1, no pending match. Reset also clears `sint_q`.
- R11: `match_o[i]` is never high in the cycle after a cycle in which `tick_i[i]` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 3 | Per-channel advance enable |
| wr_sel | input | 2 | Channel addressed by a write |
| cnt_wr | input | 1 | Counter write strobe |
| lim_wr | input | 1 | Compare write strobe |
| wr_data | input | 64 | Write word (bit 63 is a flag) |
| rd_sel | input | 2 | Channel shown on the read outputs |
| sint_clr | input | 2 | Clear strobes for the interrupt bits |
| rd_cnt | output | 64 | Selected counter word with the stored flag |
| rd_lim | output | 64 | Selected compare word with the disable flag |
| match_o | output | 3 | One-cycle match pulse per channel |
| sint_q | output | 2 | Software-interrupt bits (0 timer, 1 system timer) |

## Verification
The compare path is tried with several patterns, and each one separates a different rule:
- A limit a few ticks ahead confirms the exact firing tick.
- A limit equal to the count, and a limit below it, confirm the late-fire rule rather than silent loss.
- A zero limit and a disabled limit confirm that nothing fires.
- A limit next to the top of the count range, with the run carried across the wrap, confirms that the match and the wrap coexist.

Each run also counts the pulses to catch a second firing, and it checks which interrupt bit was set, which tells the dedicated timer bit apart from the shared one. Directed cases cover the following:
- a compare cancelled while pending;
- a clear that collides with a set;
- a counter write that races a tick;
- a reset in the middle of operation.

// File: rtl/tick_pkg.sv
`timescale 1ns/1ps
package tick_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_LATE  = 2'd2
    } arm_state_e;

    localparam int SINT_W      = 2;
    localparam int SINT_TIMER  = 0;
    localparam int SINT_SYSTEM = 1;

endpackage

// File: rtl/tick_chan.sv
`timescale 1ns/1ps
module tick_chan
    import tick_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cnt_we_i,
    input  logic             lim_we_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_view_o,
    output logic [CNT_W-1:0] lim_view_o,
    output logic             match_o
);

    localparam int VAL_W = CNT_W - 1;

    typedef struct packed {
        logic [VAL_W-1:0] cnt;
        logic             npt;
        logic [VAL_W-1:0] lim;
        logic             dis;
        arm_state_e       st;
        logic             match;
    } chan_s;

    chan_s cur_q, nxt_d;
    logic [VAL_W-1:0] cnt_inc;
    logic [VAL_W-1:0] wval;

    assign cnt_inc = cur_q.cnt + {{(VAL_W-1){1'b0}}, 1'b1};
    assign wval    = wdata_i[VAL_W-1:0];

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.match = 1'b0;

        if (cnt_we_i) begin
            nxt_d.cnt = wval;
            nxt_d.npt = wdata_i[CNT_W-1];
        end else if (tick_i) begin
            nxt_d.cnt = cnt_inc;
            if (cur_q.st == ST_ARMED && cnt_inc == cur_q.lim) begin
                nxt_d.match = 1'b1;
                nxt_d.st    = ST_IDLE;
            end else if (cur_q.st == ST_LATE) begin
                nxt_d.match = 1'b1;
                nxt_d.st    = ST_IDLE;
            end
        end

        if (lim_we_i) begin
            nxt_d.lim = wval;
            nxt_d.dis = wdata_i[CNT_W-1];
            if (wval == '0 || wdata_i[CNT_W-1]) begin
                nxt_d.st = ST_IDLE;
            end else if (wval <= nxt_d.cnt) begin
                nxt_d.st = ST_LATE;
            end else begin
                nxt_d.st = ST_ARMED;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.cnt   <= '0;
            cur_q.npt   <= 1'b1;
            cur_q.lim   <= '0;
            cur_q.dis   <= 1'b1;
            cur_q.st    <= ST_IDLE;
            cur_q.match <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cnt_view_o = {cur_q.npt, cur_q.cnt};
    assign lim_view_o = {cur_q.dis, cur_q.lim};
    assign match_o    = cur_q.match;

endmodule

// File: rtl/tick_sint.sv
`timescale 1ns/1ps
module tick_sint
    import tick_pkg::*;
#(
    parameter int N_TMR    = 3,
    parameter int TM_CHANS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TMR-1:0]  match_i,
    input  logic [SINT_W-1:0] clr_i,
    output logic [SINT_W-1:0] sint_o
);

    typedef struct packed {
        logic [SINT_W-1:0] bits;
    } sint_s;

    sint_s reg_q, reg_d;
    logic [SINT_W-1:0] set_vec;

    always_comb begin
        set_vec = '0;
        for (int i = 0; i < N_TMR; i++) begin
            if (i < TM_CHANS) begin
                set_vec[SINT_TIMER] = set_vec[SINT_TIMER] | match_i[i];
            end else begin
                set_vec[SINT_SYSTEM] = set_vec[SINT_SYSTEM] | match_i[i];
            end
        end
    end

    always_comb begin
        reg_d      = reg_q;
        reg_d.bits = (reg_q.bits & ~clr_i) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q.bits <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign sint_o = reg_q.bits;

endmodule

// File: rtl/tick_cmp_unit.sv
`timescale 1ns/1ps
module tick_cmp_unit
    import tick_pkg::*;
#(
    parameter int N_TMR    = 3,
    parameter int CNT_W    = 64,
    parameter int TM_CHANS = 1,
    parameter int SEL_W    = (N_TMR > 1) ? $clog2(N_TMR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TMR-1:0]  tick_i,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic              cnt_wr,
    input  logic              lim_wr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic [SINT_W-1:0] sint_clr,
    output logic [CNT_W-1:0]  rd_cnt,
    output logic [CNT_W-1:0]  rd_lim,
    output logic [N_TMR-1:0]  match_o,
    output logic [SINT_W-1:0] sint_q
);

    logic [CNT_W-1:0] cnt_view [N_TMR];
    logic [CNT_W-1:0] lim_view [N_TMR];

    for (genvar g = 0; g < N_TMR; g++) begin : g_chan
        logic sel_hit;
        assign sel_hit = (wr_sel == SEL_W'(g));

        tick_chan #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (tick_i[g]),
            .cnt_we_i   (cnt_wr & sel_hit),
            .lim_we_i   (lim_wr & sel_hit),
            .wdata_i    (wr_data),
            .cnt_view_o (cnt_view[g]),
            .lim_view_o (lim_view[g]),
            .match_o    (match_o[g])
        );
    end

    always_comb begin
        rd_cnt = '0;
        rd_lim = '0;
        for (int i = 0; i < N_TMR; i++) begin
            if (rd_sel == SEL_W'(i)) begin
                rd_cnt = cnt_view[i];
                rd_lim = lim_view[i];
            end
        end
    end

    tick_sint #(
        .N_TMR    (N_TMR),
        .TM_CHANS (TM_CHANS)
    ) u_sint (
        .clk     (clk),
        .rst_n   (rst_n),
        .match_i (match_o),
        .clr_i   (sint_clr),
        .sint_o  (sint_q)
    );

endmodule

// File: rtl/tick_cmp_chk.sv
`timescale 1ns/1ps
module tick_cmp_chk #(
    parameter int N_TMR    = 3,
    parameter int CNT_W    = 64,
    parameter int TM_CHANS = 1,
    parameter int SEL_W    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_TMR-1:0] tick_i,
    input logic [SEL_W-1:0] wr_sel,
    input logic             cnt_wr,
    input logic             lim_wr,
    input logic [CNT_W-1:0] wr_data,
    input logic [SEL_W-1:0] rd_sel,
    input logic [1:0]       sint_clr,
    input logic [CNT_W-1:0] rd_cnt,
    input logic [CNT_W-1:0] rd_lim,
    input logic [N_TMR-1:0] match_o,
    input logic [1:0]       sint_q
);

    // Counter write read back whole, flag included (R1)
    assert_cnt_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && wr_sel == '0 && rd_sel == '0)
        |=> (rd_sel != '0 || rd_cnt == $past(wr_data)));

    // Compare write read back whole, disable flag included (R4)
    assert_lim_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_wr && wr_sel == '0 && rd_sel == '0)
        |=> (rd_sel != '0 || rd_lim == $past(wr_data)));

    // Timer-bit set follows a channel 0 match (R9)
    assert_tm_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        match_o[0] |=> sint_q[0]);

    // Shared system bit set follows any other channel match (R9)
    assert_sm_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|match_o[N_TMR-1:TM_CHANS]) |=> sint_q[1]);

    // Clear without a colliding set empties the bit (R9)
    assert_tm_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sint_clr[0] && !match_o[0]) |=> !sint_q[0]);

    // No pulse without a preceding tick (R11)
    for (genvar g = 0; g < N_TMR; g++) begin : g_tick
        assert_match_needs_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !tick_i[g] |=> !match_o[g]);
    end

endmodule

bind tick_cmp_unit tick_cmp_chk #(
    .N_TMR    (N_TMR),
    .CNT_W    (CNT_W),
    .TM_CHANS (TM_CHANS),
    .SEL_W    (SEL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .wr_sel   (wr_sel),
    .cnt_wr   (cnt_wr),
    .lim_wr   (lim_wr),
    .wr_data  (wr_data),
    .rd_sel   (rd_sel),
    .sint_clr (sint_clr),
    .rd_cnt   (rd_cnt),
    .rd_lim   (rd_lim),
    .match_o  (match_o),
    .sint_q   (sint_q)
);

// File: tb/tick_cmp_unit_tb.sv
`timescale 1ns/1ps
module tick_cmp_unit_tb;

    localparam logic [63:0] FLAG  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] M63   = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam int          RUN   = 40;
    localparam int          NV    = 8;

    // channel, counter load, compare load
    localparam int          V_CH  [NV] = '{0, 1, 2, 0, 1, 2, 0, 1};
    localparam logic [63:0] V_CNT [NV] = '{64'd10, 64'd0, 64'd100, 64'd50,
                                           64'd5, 64'd5, 64'h7FFF_FFFF_FFFF_FFFD, 64'd7};
    localparam logic [63:0] V_LIM [NV] = '{64'd15, 64'd1, 64'd100, 64'd20,
                                           64'd0, 64'h8000_0000_0000_0009,
                                           64'h7FFF_FFFF_FFFF_FFFF, 64'd37};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  tick_i = '0;
    logic [1:0]  wr_sel = '0;
    logic        cnt_wr = 1'b0;
    logic        lim_wr = 1'b0;
    logic [63:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [1:0]  sint_clr = '0;
    logic [63:0] rd_cnt, rd_lim;
    logic [2:0]  match_o;
    logic [1:0]  sint_q;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tick_cmp_unit u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_sel(wr_sel),
        .cnt_wr(cnt_wr), .lim_wr(lim_wr), .wr_data(wr_data), .rd_sel(rd_sel),
        .sint_clr(sint_clr), .rd_cnt(rd_cnt), .rd_lim(rd_lim),
        .match_o(match_o), .sint_q(sint_q)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%h expected 0x%h", req, act, exp);
        end
    endtask

    task automatic wr_cnt(input int ch, input logic [63:0] v);
        wr_sel = 2'(ch); wr_data = v; cnt_wr = 1'b1;
        cyc();
        cnt_wr = 1'b0;
    endtask

    task automatic wr_lim(input int ch, input logic [63:0] v);
        wr_sel = 2'(ch); wr_data = v; lim_wr = 1'b1;
        cyc();
        lim_wr = 1'b0;
    endtask

    // tick one channel n times; returns number of pulses seen
    task automatic run_ticks(input int ch, input int n, output int pulses);
        pulses = 0;
        for (int j = 0; j < n; j++) begin
            tick_i[ch] = 1'b1;
            cyc();
            if (match_o[ch]) pulses++;
        end
        tick_i = '0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual 0x%h expected 0x%h", 64'd1, 64'd0);
        summary();
    end

    initial begin
        int pulses;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R10: reset state of every channel
        for (int c = 0; c < 3; c++) begin
            rd_sel = 2'(c);
            #0.1;
            chk(rd_cnt == FLAG, "R10 count", rd_cnt, FLAG);
            chk(rd_lim == FLAG, "R10 limit", rd_lim, FLAG);
        end
        chk(sint_q == 2'b00 && match_o == 3'b000, "R10 sint/match",
            {59'd0, match_o, sint_q}, 64'd0);

        // Vector table: R5 ahead, R8 late, R7 none, R6 single pulse, R9 bit, R3 wrap
        for (int v = 0; v < NV; v++) begin
            int ch, first, npulse, exp_first, exp_n;
            logic [63:0] c, l, exp_cnt;
            logic [1:0] exp_sint;
            string tag;
            ch = V_CH[v]; c = V_CNT[v]; l = V_LIM[v];
            wr_cnt(ch, c);
            wr_lim(ch, l);
            if ((l & M63) == 0 || l[63]) begin
                exp_first = 0; tag = "R7";
            end else if ((l & M63) > (c & M63)) begin
                exp_first = int'((l & M63) - (c & M63)); tag = "R5";
            end else begin
                exp_first = 1; tag = "R8";
            end
            exp_n = (exp_first != 0) ? 1 : 0;
            first = 0; npulse = 0;
            for (int j = 1; j <= RUN; j++) begin
                tick_i[ch] = 1'b1;
                cyc();
                if (match_o[ch]) begin
                    npulse++;
                    if (first == 0) first = j;
                end
            end
            tick_i = '0;
            cyc();
            chk(first == exp_first, tag, 64'(first), 64'(exp_first));
            chk(npulse == exp_n, "R6 pulse count", 64'(npulse), 64'(exp_n));
            exp_sint = (exp_n == 0) ? 2'b00 : ((ch == 0) ? 2'b01 : 2'b10);
            chk(sint_q == exp_sint, "R9 sint bit", 64'(sint_q), 64'(exp_sint));
            rd_sel = 2'(ch);
            exp_cnt = (c + 64'(RUN)) & M63;
            #0.1;
            chk(rd_cnt == exp_cnt, "R2/R3 count after run", rd_cnt, exp_cnt);
            sint_clr = 2'b11;
            cyc();
            sint_clr = 2'b00;
            chk(sint_q == 2'b00, "R9 clear", 64'(sint_q), 64'd0);
        end

        // R1, R2: flag kept, advance by tick
        wr_cnt(1, 64'h8000_0000_0000_0005);
        rd_sel = 2'd1;
        #0.1;
        chk(rd_cnt == 64'h8000_0000_0000_0005, "R1 readback", rd_cnt, 64'h8000_0000_0000_0005);
        run_ticks(1, 3, pulses);
        chk(rd_cnt == 64'h8000_0000_0000_0008, "R2 advance", rd_cnt, 64'h8000_0000_0000_0008);
        repeat (4) cyc();
        chk(rd_cnt == 64'h8000_0000_0000_0008, "R2 hold", rd_cnt, 64'h8000_0000_0000_0008);

        // R2: write beats tick
        tick_i[0] = 1'b1;
        wr_cnt(0, 64'h77);
        tick_i = '0;
        rd_sel = 2'd0;
        #0.1;
        chk(rd_cnt == 64'h77, "R2 write priority", rd_cnt, 64'h77);

        // R3: wrap keeps flag
        wr_cnt(2, 64'hFFFF_FFFF_FFFF_FFFF);
        run_ticks(2, 1, pulses);
        rd_sel = 2'd2;
        #0.1;
        chk(rd_cnt == FLAG, "R3 wrap", rd_cnt, FLAG);

        // R4: compare readback with disable flag
        wr_lim(0, 64'h8000_0000_0000_1234);
        rd_sel = 2'd0;
        #0.1;
        chk(rd_lim == 64'h8000_0000_0000_1234, "R4 readback", rd_lim, 64'h8000_0000_0000_1234);

        // R7: zero compare cancels pending
        wr_cnt(0, 64'd0);
        wr_lim(0, 64'd10);
        run_ticks(0, 3, pulses);
        wr_lim(0, 64'd0);
        run_ticks(0, 20, pulses);
        chk(pulses == 0, "R7 zero cancel", 64'(pulses), 64'd0);

        // R7: disable flag cancels pending
        wr_cnt(1, 64'd0);
        wr_lim(1, 64'd8);
        run_ticks(1, 2, pulses);
        wr_lim(1, 64'h8000_0000_0000_0008);
        run_ticks(1, 20, pulses);
        chk(pulses == 0, "R7 disable cancel", 64'(pulses), 64'd0);
        chk(sint_q == 2'b00, "R7 no sint", 64'(sint_q), 64'd0);

        // R9: set wins over a colliding clear
        wr_cnt(0, 64'd0);
        wr_lim(0, 64'd1);
        tick_i[0] = 1'b1;
        cyc();
        tick_i = '0;
        chk(match_o[0] == 1'b1, "R5 match at limit", 64'(match_o), 64'd1);
        sint_clr = 2'b01;
        cyc();
        sint_clr = 2'b00;
        chk(sint_q[0] == 1'b1, "R9 set wins", 64'(sint_q), 64'd1);
        sint_clr = 2'b01;
        cyc();
        sint_clr = 2'b00;
        chk(sint_q == 2'b00, "R9 clear after", 64'(sint_q), 64'd0);

        // R10: reset mid-operation
        wr_cnt(0, 64'd5);
        wr_lim(0, 64'd9);
        rst_n = 1'b0;
        cyc();
        rst_n = 1'b1;
        rd_sel = 2'd0;
        #0.1;
        chk(rd_cnt == FLAG, "R10 count after reset", rd_cnt, FLAG);
        chk(rd_lim == FLAG, "R10 limit after reset", rd_lim, FLAG);
        run_ticks(0, 10, pulses);
        chk(pulses == 0, "R10 no pending match", 64'(pulses), 64'd0);

        summary();
    end

endmodule